// File: doc/BRIEF.md
# Multi-Level Delta-Sigma Modulator

This block converts oversampled two's-complement audio into a stream of 3-bit level codes for a multi-level DAC further down the chain. An interpolation filter upstream delivers a new sample at eight times the audio rate, marked by a one-cycle strobe. The modulator itself advances at sixty-four times the audio rate, so every sample stays in place for eight modulator updates. The update rate comes from a fixed divider on the system clock.

The loop is a fourth-order noise shaper. Four delaying integrators form a chain, and the first one takes the held sample minus the fed-back quantizer level. The quantizer reads a weighted sum of all four integrator states. The weights are 2, 1.5, 0.5 and 1/16, which puts all four noise-transfer poles at z = 0.5 and all four zeros at DC. The integrators have guard bits and clamp at their signed limits, so an overload cannot wrap a state around. A mute input clears the loop and produces a code pattern whose average is bipolar zero.

Top module: `mlds_modulator`

## Requirements
- R1: Code k (0 to 7) stands for the level (2k-7)/7 of full scale, where full scale is 2^(IN_W-1) input LSBs. Inside the loop the input is scaled by 7, and code k feeds back (2k-7)*2^(IN_W-1).
- R2: While rst_ni is low, code_o is 3 at once, every integrator is zero and the held sample is zero.
- R3: The modulator updates once every TICK_DIV clocks. The first update comes at the TICK_DIV-th rising edge after reset is released. code_o changes only on an update.
- R4: sample_i is loaded only on a clock where sample_valid_i is high. sample_i has no effect at any other time, and the held value feeds every update until the next load.
- R5: On each update the first integrator adds (7*sample - feedback level). Integrator k (k = 2 to 4) adds the state of integrator k-1 as it was before the update. The quantizer input is v = 2*s1 + s2 + floor(s2/2) + floor(s3/2) + floor(s4/16).
- R6: The quantizer output is code = floor(v / 2^IN_W) + 4, clamped to the range 0 to 7. code_o takes this value on the update, and the same code is the one fed back in that update.
- R7: An integrator whose sum leaves the signed ACC_W-bit range is clamped to the nearest limit and never wraps.
- R8: While mute_i is high, all integrators are zero one clock later. On each update, code_o becomes 4 if it was 3, and 3 otherwise.
- R9: For a constant input within half of full scale, the mean code over 1024 updates equals (7*x/FS + 7)/2, within 32/1024.
- R10: For a constant full-scale input, the loop stays bounded. The mean code over 1024 updates is at least 6 for positive full scale and at most 1 for negative full scale.
- R11: After the loop has been cleared by reset or mute, the first update outputs code 4, whatever the input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | IN_W | Oversampled two's-complement sample |
| sample_valid_i | input | 1 | Load strobe for sample_i, one cycle at 8x the audio rate |
| mute_i | input | 1 | Clears the loop and outputs the bipolar-zero pattern |
| code_o | output | 3 | Level code for the multi-level DAC |

## Verification
Any wrong integrator value reaches the quantizer sum at once, so a fault in state or arithmetic changes code_o on the very next update. The behavioural model follows the code stream exactly and catches that change. A feedback level or input scaling that is only slightly wrong may leave single codes plausible. Because the first integrator is bounded, the same fault then shows up as a shift in the mean code over a thousand updates. The DC checks at two levels, and at both full-scale extremes, detect that shift.

// File: rtl/mlds_pkg.sv
package mlds_pkg;
  localparam int ORDER    = 4;
  localparam int CODE_W   = 3;
  localparam int N_LEVELS = 8;
  localparam logic [CODE_W-1:0] CODE_MID_LO = 3'd3;
  localparam logic [CODE_W-1:0] CODE_MID_HI = 3'd4;
endpackage

// File: rtl/mlds_tick.sv
module mlds_tick #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/mlds_integ.sv
module mlds_integ #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         clr_i,
  input  logic [W-1:0] add_i,
  output logic [W-1:0] st_o
);
  logic [W:0]   sum;
  logic [W-1:0] nxt;

  always_comb begin
    sum = {st_o[W-1], st_o} + {add_i[W-1], add_i};
    // clamp to signed limits on overflow
    if (sum[W] == sum[W-1]) nxt = sum[W-1:0];
    else                    nxt = {sum[W], {(W-1){~sum[W]}}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   st_o <= '0;
    else if (clr_i) st_o <= '0;
    else if (en_i)  st_o <= nxt;
  end
endmodule

// File: rtl/mlds_quant.sv
module mlds_quant import mlds_pkg::*; #(
  parameter int ACC_W = 32,
  parameter int IN_W  = 24
) (
  input  logic [ORDER-1:0][ACC_W-1:0] st_i,
  output logic [CODE_W-1:0]           code_o
);
  localparam int SUM_W = ACC_W + 3;
  localparam logic signed [SUM_W-1:0] LO_Q = SUM_W'(-(N_LEVELS / 2));
  localparam logic signed [SUM_W-1:0] HI_Q = SUM_W'(N_LEVELS / 2 - 1);

  logic signed [SUM_W-1:0] e0, e1, e2, e3, v, q;

  always_comb begin
    e0 = SUM_W'($signed(st_i[0]));
    e1 = SUM_W'($signed(st_i[1]));
    e2 = SUM_W'($signed(st_i[2]));
    e3 = SUM_W'($signed(st_i[3]));
    // feedforward weights 2, 1.5, 0.5, 1/16
    v  = (e0 <<< 1) + e1 + (e1 >>> 1) + (e2 >>> 1) + (e3 >>> 4);
    q  = v >>> IN_W;
    if (q < LO_Q)      code_o = '0;
    else if (q > HI_Q) code_o = CODE_W'(N_LEVELS - 1);
    else               code_o = {~q[CODE_W-1], q[CODE_W-2:0]};
  end
endmodule

// File: rtl/mlds_modulator.sv
module mlds_modulator import mlds_pkg::*; #(
  parameter int IN_W     = 24,
  parameter int GUARD    = 5,
  parameter int TICK_DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IN_W-1:0]   sample_i,
  input  logic              sample_valid_i,
  input  logic              mute_i,
  output logic [CODE_W-1:0] code_o
);
  localparam int ACC_W = IN_W + 3 + GUARD;

  logic [IN_W-1:0]             sample_q;
  logic                        tick;
  logic                        step_en;
  logic [ORDER-1:0][ACC_W-1:0] st;
  logic [ORDER-1:0][ACC_W-1:0] add;
  logic [CODE_W-1:0]           q_code;
  logic signed [ACC_W-1:0]     x_ext, x7, fb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             sample_q <= '0;
    else if (sample_valid_i) sample_q <= sample_i;
  end

  mlds_tick #(.DIV(TICK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  assign step_en = tick & ~mute_i;

  always_comb begin
    x_ext = ACC_W'($signed(sample_q));
    x7    = (x_ext <<< 3) - x_ext;
    // level (2k-7) * 2^(IN_W-1)
    fb    = (ACC_W'({1'b0, q_code, 1'b1}) - ACC_W'(8)) <<< (IN_W - 1);
  end

  assign add[0] = x7 - fb;

  for (genvar k = 0; k < ORDER; k++) begin : g_stage
    if (k > 0) begin : g_chain
      assign add[k] = st[k-1];
    end
    mlds_integ #(.W(ACC_W)) u_integ (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (step_en),
      .clr_i  (mute_i),
      .add_i  (add[k]),
      .st_o   (st[k])
    );
  end

  mlds_quant #(.ACC_W(ACC_W), .IN_W(IN_W)) u_quant (
    .st_i   (st),
    .code_o (q_code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_o <= CODE_MID_LO;
    else if (tick) begin
      if (mute_i) code_o <= (code_o == CODE_MID_LO) ? CODE_MID_HI : CODE_MID_LO;
      else        code_o <= q_code;
    end
  end
endmodule

// File: rtl/mlds_checker.sv
module mlds_checker import mlds_pkg::*; #(
  parameter int IN_W  = 24,
  parameter int ACC_W = 32
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        tick_i,
  input logic                        mute_i,
  input logic                        valid_i,
  input logic [CODE_W-1:0]           code_i,
  input logic [IN_W-1:0]             sample_q_i,
  input logic [ORDER-1:0][ACC_W-1:0] st_i
);
  assert_code_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(code_i));

  assert_sample_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(sample_q_i));

  assert_mute_up_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && mute_i && code_i == CODE_MID_LO) |=> code_i == CODE_MID_HI);

  assert_mute_down_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && mute_i && code_i != CODE_MID_LO) |=> code_i == CODE_MID_LO);

  assert_mute_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mute_i |=> st_i == '0);

  for (genvar k = 1; k < ORDER; k++) begin : g_wrap
    assert_no_wrap_pos_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && !mute_i && !st_i[k][ACC_W-1] && !st_i[k-1][ACC_W-1]) |=> !st_i[k][ACC_W-1]);
    assert_no_wrap_neg_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && !mute_i && st_i[k][ACC_W-1] && st_i[k-1][ACC_W-1]) |=> st_i[k][ACC_W-1]);
  end
endmodule

bind mlds_modulator mlds_checker #(.IN_W(IN_W), .ACC_W(ACC_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick),
  .mute_i     (mute_i),
  .valid_i    (sample_valid_i),
  .code_i     (code_o),
  .sample_q_i (sample_q),
  .st_i       (st)
);

// File: tb/mlds_modulator_bench.sv
module mlds_modulator_bench;
  localparam int IN_W  = 24;
  localparam int GUARD = 5;
  localparam int DIV   = 4;
  localparam int ACC_W = IN_W + 3 + GUARD;
  localparam longint FS = longint'(1) << (IN_W - 1);
  localparam longint SMAX = (longint'(1) << (ACC_W - 1)) - 1;
  localparam longint SMIN = -(longint'(1) << (ACC_W - 1));

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [IN_W-1:0] sample = '0;
  logic            valid = 1'b0;
  logic            mute = 1'b0;
  logic [2:0]      code;

  int     tests = 0, fails = 0;
  string  cur_req = "R5";
  bit     valid_en = 1'b1;
  int     vphase = 0;
  bit     meas = 1'b0;
  longint sum_codes = 0;
  bit     last_tick = 1'b0;

  longint ms [4];
  longint mx = 0;
  int     mcnt = 0;
  int     mcode = 3;

  always #5 clk = ~clk;

  mlds_modulator #(.IN_W(IN_W), .GUARD(GUARD), .TICK_DIV(DIV)) u_mlds_modulator (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .sample_i       (sample),
    .sample_valid_i (valid),
    .mute_i         (mute),
    .code_o         (code)
  );

  task automatic chk(string req, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_range(string req, longint act, longint lo, longint hi);
    tests++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  function automatic longint clampv(longint v);
    if (v > SMAX) return SMAX;
    if (v < SMIN) return SMIN;
    return v;
  endfunction

  // behavioural model of one rising edge
  task automatic model_edge(bit v_in, longint smp, bit mu);
    bit     tk;
    longint acc, lvl;
    int     qc;
    longint nx [4];
    tk  = (mcnt == DIV - 1);
    acc = 2 * ms[0] + ms[1] + (ms[1] >>> 1) + (ms[2] >>> 1) + (ms[3] >>> 4);
    acc = acc >>> IN_W;
    if (acc < -4)     qc = 0;
    else if (acc > 3) qc = 7;
    else              qc = int'(acc) + 4;
    lvl = longint'(2 * qc - 7) * FS;
    if (mu) begin
      for (int k = 0; k < 4; k++) ms[k] = 0;
    end else if (tk) begin
      nx[0] = clampv(ms[0] + 7 * mx - lvl);
      for (int k = 1; k < 4; k++) nx[k] = clampv(ms[k] + ms[k-1]);
      for (int k = 0; k < 4; k++) ms[k] = nx[k];
    end
    if (tk) mcode = mu ? ((mcode == 3) ? 4 : 3) : qc;
    if (v_in) mx = smp;
    mcnt = tk ? 0 : mcnt + 1;
    last_tick = tk;
  endtask

  // called at a falling edge: drive, model the next rising edge, compare at next falling edge
  task automatic step();
    valid = valid_en && (vphase == 0);
    vphase = (vphase + 1) % (8 * DIV);
    model_edge(valid, longint'($signed(sample)), mute);
    @(negedge clk);
    chk({cur_req, " cycle"}, code, mcode);
    if (meas && last_tick) sum_codes += code;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic measure(int n, output longint s);
    sum_codes = 0;
    meas = 1'b1;
    run(n);
    meas = 1'b0;
    s = sum_codes;
  endtask

  task automatic do_reset();
    #2 rst_n = 1'b0;
    #1 chk("R2 reset code", code, 3);
    for (int k = 0; k < 4; k++) ms[k] = 0;
    mx = 0; mcnt = 0; mcode = 3; vphase = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R2 reset held", code, 3);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    longint s;
    int     prev;
    @(negedge clk);
    do_reset();

    // R3, R11: first update after reset at the DIV-th edge, from cleared loop gives 4
    cur_req = "R3";
    for (int k = 1; k <= DIV; k++) begin
      step();
      chk((k < DIV) ? "R3 no update yet" : "R11 first code", code, (k < DIV) ? 3 : 4);
    end

    // R1, R5, R6, R9: DC at +0.25 FS
    cur_req = "R5 R6";
    sample = IN_W'(FS / 4);
    run(4096);
    measure(4096, s);
    chk_range("R9 R1 dc +0.25", s, 4480 - 32, 4480 + 32);

    // DC at -0.5 FS
    sample = IN_W'(-(FS / 2));
    run(4096);
    measure(4096, s);
    chk_range("R9 R1 dc -0.5", s, 1792 - 32, 1792 + 32);

    // R4: sample_i churns without strobe, held -0.5 keeps the mean
    cur_req = "R4";
    valid_en = 1'b0;
    sum_codes = 0;
    meas = 1'b1;
    for (int i = 0; i < 512; i++) begin
      sample = IN_W'(i * 7919 + 3000000);
      step();
    end
    meas = 1'b0;
    chk_range("R4 ignored input", sum_codes, 224 - 32, 224 + 32);
    valid_en = 1'b1;

    // R8: mute gives 3/4 alternation on updates
    cur_req = "R8";
    mute = 1'b1;
    prev = -1;
    for (int i = 0; i < 64; i++) begin
      step();
      if (last_tick && i > 8) begin
        chk_range("R8 mute code", code, 3, 4);
        if (prev >= 0) chk("R8 alternation", (code != prev), 1);
        prev = code;
      end
    end
    // R11: first update after unmute is 4
    mute = 1'b0;
    cur_req = "R11";
    sample = IN_W'(FS / 2);
    last_tick = 1'b0;
    while (!last_tick) step();
    chk("R11 after mute", code, 4);

    // R7, R10: full scale both ways
    cur_req = "R7";
    sample = IN_W'(FS - 1);
    run(4096);
    measure(4096, s);
    chk_range("R10 +full scale", s, 6144, 7168);
    sample = IN_W'(-FS);
    run(4096);
    measure(4096, s);
    chk_range("R10 -full scale", s, 0, 1024);

    // R2: reset mid-run
    do_reset();
    cur_req = "R2";
    sample = '0;
    run(16);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule